// File: doc/BRIEF.md
# Accumulator and Multiplier-Quotient Execute Unit

This unit is the arithmetic core of a single-accumulator machine. It holds two signed registers of `WIDTH` bits (default 40): the accumulator and the multiplier-quotient register. A fetch sequencer hands it an 8-bit opcode and a memory operand together with a one-cycle start strobe. The unit applies the operation and reports completion with a one-cycle done pulse.

Loads, stores, adds, subtracts, shifts and register transfers finish in one cycle. Multiply and divide run as sequential loops, one bit per cycle, over operand magnitudes. Their signs are applied when the loop ends. The product spreads across both registers. Division leaves the quotient in the multiplier-quotient register and the remainder in the accumulator.

The word to be written to memory is always the accumulator's content. A sign flag supports conditional branches. Overflow and divide-error flags describe the last operation the unit accepted.

Top module: `acc_mq_exec`

## Requirements
- R1: After reset, the accumulator and multiplier-quotient register are zero, done, overflow and divError are 0, and acNonNeg is 1.
- R2: Opcode 8'h01 loads the operand into the accumulator, 8'h02 loads its negation, 8'h03 loads its absolute value and 8'h04 loads the negated absolute value. Each completes with done exactly one cycle after the start cycle.
- R3: Opcode 8'h09 loads the operand into the multiplier-quotient register and leaves the accumulator unchanged. Opcode 8'h0A copies that register into the accumulator. Opcode 8'h21 completes in one cycle with both registers unchanged. storeData always equals the accumulator.
- R4: Opcode 8'h05 adds the operand and 8'h07 adds its absolute value. Opcode 8'h06 subtracts the operand and 8'h08 subtracts its absolute value. Results wrap in two's complement, and overflow is 1 exactly when the signed result wrapped.
- R5: Opcode 8'h14 shifts the accumulator left by one, with overflow set when the sign bit changes. Opcode 8'h15 shifts it right by one arithmetically.
- R6: Opcode 8'h0B forms the signed 2*WIDTH-bit product of the operand and the multiplier-quotient register. The upper half goes to the accumulator and the lower half to the multiplier-quotient register. Done rises WIDTH+1 clock edges after the edge that accepted start.
- R7: Opcode 8'h0C divides the accumulator by the operand with the same latency as R6. The quotient, truncated toward zero, goes to the multiplier-quotient register. The remainder, carrying the dividend's sign, goes to the accumulator.
- R8: A divide by zero completes in one cycle, sets divError and leaves both registers unchanged.
- R9: A start raised while a multiply or divide is in progress is ignored.
- R10: acNonNeg is the inverse of the accumulator's sign bit.
- R11: Overflow and divError are refreshed by every accepted operation; any opcode not listed above completes in one cycle and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the operation on opcode and operand |
| opcode | input | 8 | Operation code |
| operand | input | WIDTH | Memory operand, two's complement |
| done | output | 1 | One-cycle completion pulse |
| storeData | output | WIDTH | Accumulator content, the word to store |
| acNonNeg | output | 1 | Accumulator is zero or positive |
| overflow | output | 1 | Last add, subtract or left shift wrapped |
| divError | output | 1 | Last divide had a zero divisor |

## Verification
On every cycle the assertions check four things. Accumulator and multiplier-quotient register hold still while a multiply or divide loop is stepping. A rejected divide leaves both registers untouched. Overflow can only rise from a single-cycle operation. The control moves only from stepping to stepping or finishing, and emits at most one strobe per cycle.

The numeric results need the directed scenarios. These cover the load forms, signed products and quotients in all four sign combinations, overflow at the extremes, the exact multi-cycle latency and a start ignored while busy.

// File: rtl/acc_mq_pkg.sv
package acc_mq_pkg;
  localparam logic [7:0] OP_LD     = 8'h01;
  localparam logic [7:0] OP_LDNEG  = 8'h02;
  localparam logic [7:0] OP_LDABS  = 8'h03;
  localparam logic [7:0] OP_LDNABS = 8'h04;
  localparam logic [7:0] OP_ADD    = 8'h05;
  localparam logic [7:0] OP_SUB    = 8'h06;
  localparam logic [7:0] OP_ADDABS = 8'h07;
  localparam logic [7:0] OP_SUBABS = 8'h08;
  localparam logic [7:0] OP_LDMQ   = 8'h09;
  localparam logic [7:0] OP_MQ2AC  = 8'h0A;
  localparam logic [7:0] OP_MUL    = 8'h0B;
  localparam logic [7:0] OP_DIV    = 8'h0C;
  localparam logic [7:0] OP_SHL    = 8'h14;
  localparam logic [7:0] OP_SHR    = 8'h15;
  localparam logic [7:0] OP_STORE  = 8'h21;

  // Strobes from control to datapath; at most one is high per cycle.
  typedef struct packed {
    logic execOne;
    logic mulBegin;
    logic divBegin;
    logic divReject;
    logic step;
    logic finish;
  } ctrlStrobes_t;
endpackage

// File: rtl/acc_mq_ctrl.sv
module acc_mq_ctrl
  import acc_mq_pkg::*;
#(
  parameter int WIDTH = 40
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [7:0]   opcode,
  input  logic         divisorZero,
  output ctrlStrobes_t strb,
  output logic         done
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST_STEP = CW'(WIDTH - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_t;
  state_t state;
  logic [CW-1:0] stepCnt;

  always_comb begin
    strb = '0;
    unique case (state)
      S_IDLE: if (start) begin
        if (opcode == OP_MUL) strb.mulBegin = 1'b1;
        else if (opcode == OP_DIV) begin
          if (divisorZero) strb.divReject = 1'b1;
          else             strb.divBegin  = 1'b1;
        end else strb.execOne = 1'b1;
      end
      S_RUN:   strb.step   = 1'b1;
      S_FIN:   strb.finish = 1'b1;
      default: strb = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= strb.execOne | strb.divReject | strb.finish;
      unique case (state)
        S_IDLE: if (strb.mulBegin || strb.divBegin) begin
          state   <= S_RUN;
          stepCnt <= LAST_STEP;
        end
        S_RUN: begin
          if (stepCnt == '0) state <= S_FIN;
          else               stepCnt <= stepCnt - 1'b1;
        end
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R9: while a loop runs, control only keeps stepping or finishes
  a_r9_run_not_interrupted: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RUN) |=> (state == S_RUN || state == S_FIN));

  // R9: a single strobe at a time
  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));
endmodule

// File: rtl/acc_mq_dpath.sv
module acc_mq_dpath
  import acc_mq_pkg::*;
#(
  parameter int WIDTH = 40
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strb,
  input  logic [7:0]       opcode,
  input  logic [WIDTH-1:0] operand,
  output logic             divisorZero,
  output logic [WIDTH-1:0] acOut,
  output logic             ovfOut,
  output logic             divErrOut
);
  localparam int PW = 2 * WIDTH;

  logic [WIDTH-1:0] ac, mq, lo, mag;
  logic [WIDTH:0]   hi;
  logic             negRes, negRem, isDiv, ovf, divErr;

  logic [WIDTH-1:0] opAbs, mqAbs, acAbs, addB, sumV, difV;
  logic             ovfAdd, ovfSub;
  logic [WIDTH:0]   mulSum, divSh;
  logic             divGe;
  logic [PW-1:0]    prodMag, prodSigned;

  assign divisorZero = (operand == '0);
  assign opAbs = operand[WIDTH-1] ? -operand : operand;
  assign mqAbs = mq[WIDTH-1] ? -mq : mq;
  assign acAbs = ac[WIDTH-1] ? -ac : ac;
  assign addB  = (opcode == OP_ADDABS || opcode == OP_SUBABS) ? opAbs : operand;
  assign sumV  = ac + addB;
  assign difV  = ac - addB;
  assign ovfAdd = (ac[WIDTH-1] == addB[WIDTH-1]) && (sumV[WIDTH-1] != ac[WIDTH-1]);
  assign ovfSub = (ac[WIDTH-1] != addB[WIDTH-1]) && (difV[WIDTH-1] != ac[WIDTH-1]);

  assign mulSum = hi + (lo[0] ? {1'b0, mag} : '0);
  assign divSh  = {hi[WIDTH-1:0], lo[WIDTH-1]};
  assign divGe  = divSh >= {1'b0, mag};
  assign prodMag    = {hi[WIDTH-1:0], lo};
  assign prodSigned = negRes ? -prodMag : prodMag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ac <= '0; mq <= '0; hi <= '0; lo <= '0; mag <= '0;
      negRes <= 1'b0; negRem <= 1'b0; isDiv <= 1'b0;
      ovf <= 1'b0; divErr <= 1'b0;
    end else if (strb.execOne) begin
      ovf    <= 1'b0;
      divErr <= 1'b0;
      case (opcode)
        OP_LD:     ac <= operand;
        OP_LDNEG:  ac <= -operand;
        OP_LDABS:  ac <= opAbs;
        OP_LDNABS: ac <= -opAbs;
        OP_ADD, OP_ADDABS: begin ac <= sumV; ovf <= ovfAdd; end
        OP_SUB, OP_SUBABS: begin ac <= difV; ovf <= ovfSub; end
        OP_LDMQ:   mq <= operand;
        OP_MQ2AC:  ac <= mq;
        OP_SHL: begin
          ac  <= {ac[WIDTH-2:0], 1'b0};
          ovf <= ac[WIDTH-1] ^ ac[WIDTH-2];
        end
        OP_SHR:    ac <= {ac[WIDTH-1], ac[WIDTH-1:1]};
        default:   ;
      endcase
    end else if (strb.mulBegin) begin
      mag <= opAbs; hi <= '0; lo <= mqAbs;
      negRes <= operand[WIDTH-1] ^ mq[WIDTH-1];
      isDiv <= 1'b0; ovf <= 1'b0; divErr <= 1'b0;
    end else if (strb.divBegin) begin
      mag <= opAbs; hi <= '0; lo <= acAbs;
      negRes <= operand[WIDTH-1] ^ ac[WIDTH-1];
      negRem <= ac[WIDTH-1];
      isDiv <= 1'b1; ovf <= 1'b0; divErr <= 1'b0;
    end else if (strb.divReject) begin
      ovf    <= 1'b0;
      divErr <= 1'b1;
    end else if (strb.step) begin
      if (isDiv) begin
        hi <= divGe ? divSh - {1'b0, mag} : divSh;
        lo <= {lo[WIDTH-2:0], divGe};
      end else begin
        hi <= {1'b0, mulSum[WIDTH:1]};
        lo <= {mulSum[0], lo[WIDTH-1:1]};
      end
    end else if (strb.finish) begin
      if (isDiv) begin
        mq <= negRes ? -lo : lo;
        ac <= negRem ? -hi[WIDTH-1:0] : hi[WIDTH-1:0];
      end else begin
        ac <= prodSigned[PW-1:WIDTH];
        mq <= prodSigned[WIDTH-1:0];
      end
    end
  end

  assign acOut     = ac;
  assign ovfOut    = ovf;
  assign divErrOut = divErr;

  // R6 / R7: architectural registers hold while the loop steps
  a_r6_regs_hold_in_loop: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |=> ($stable(ac) && $stable(mq)));

  // R8: a rejected divide leaves both registers as they were
  a_r8_zero_div_no_write: assert property (@(posedge clk) disable iff (!rstN)
    $rose(divErr) |-> (ac == $past(ac) && mq == $past(mq)));

  // R4: overflow only appears after a single-cycle operation
  a_r4_ovf_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovf) |-> $past(strb.execOne));
endmodule

// File: rtl/acc_mq_exec.sv
module acc_mq_exec
  import acc_mq_pkg::*;
#(
  parameter int WIDTH = 40
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [7:0]       opcode,
  input  logic [WIDTH-1:0] operand,
  output logic             done,
  output logic [WIDTH-1:0] storeData,
  output logic             acNonNeg,
  output logic             overflow,
  output logic             divError
);
  ctrlStrobes_t strb;
  logic         divisorZero;

  acc_mq_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode),
    .divisorZero(divisorZero), .strb(strb), .done(done)
  );

  acc_mq_dpath #(.WIDTH(WIDTH)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .opcode(opcode), .operand(operand),
    .divisorZero(divisorZero), .acOut(storeData), .ovfOut(overflow),
    .divErrOut(divError)
  );

  // R10: branch flag tracks the accumulator sign
  assign acNonNeg = ~storeData[WIDTH-1];
endmodule

// File: tb/test_acc_mq_exec.sv
module test_acc_mq_exec;
  localparam int W = 40;
  localparam int MULDIV_LAT = W + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic [W-1:0] operand = '0;
  logic done, acNonNeg, overflow, divError;
  logic [W-1:0] storeData;
  int total = 0;
  int bad = 0;

  always #4ns clk = ~clk;  // 125 MHz

  acc_mq_exec #(.WIDTH(W)) i_acc_mq_exec (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode), .operand(operand),
    .done(done), .storeData(storeData), .acNonNeg(acNonNeg),
    .overflow(overflow), .divError(divError)
  );

  task automatic chk(input bit ok, input string tag, input logic [79:0] act,
                     input logic [79:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Issue one operation; returns edges after the accepting edge until done.
  task automatic issue(input logic [7:0] op, input logic [W-1:0] val, output int lat);
    @(negedge clk);
    opcode = op; operand = val; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 200) begin
      @(posedge clk); @(negedge clk);
      lat++;
    end
  endtask

  task automatic op1(input logic [7:0] op, input logic [W-1:0] val, input string tag);
    int lat;
    issue(op, val, lat);
    chk(lat == 0, tag, 80'(lat), 80'd0);
  endtask

  task automatic readMq(output logic [W-1:0] v);
    op1(8'h0A, '0, "R3 mq2ac latency");
    v = storeData;
  endtask

  task automatic t_reset();
    logic [W-1:0] m;
    chk(storeData == '0, "R1 ac reset", 80'(storeData), 0);
    chk(!done && !overflow && !divError, "R1 flags reset",
        {done, overflow, divError}, 0);
    chk(acNonNeg == 1'b1, "R1 acNonNeg reset", 80'(acNonNeg), 1);
    readMq(m);
    chk(m == '0, "R1 mq reset", 80'(m), 0);
  endtask

  task automatic t_loads();
    op1(8'h01, 40'sd123, "R2 ld lat");
    chk(storeData == 40'sd123, "R2 ld", 80'(storeData), 80'(40'sd123));
    chk(acNonNeg, "R10 positive", 80'(acNonNeg), 1);
    op1(8'h02, 40'sd123, "R2 ldneg lat");
    chk(storeData == -40'sd123, "R2 ldneg", 80'(storeData), 80'(-40'sd123));
    chk(!acNonNeg, "R10 negative", 80'(acNonNeg), 0);
    op1(8'h03, -40'sd77, "R2 ldabs lat");
    chk(storeData == 40'sd77, "R2 ldabs", 80'(storeData), 80'(40'sd77));
    op1(8'h04, 40'sd77, "R2 ldnabs lat");
    chk(storeData == -40'sd77, "R2 ldnabs pos", 80'(storeData), 80'(-40'sd77));
    op1(8'h04, -40'sd9, "R2 ldnabs lat");
    chk(storeData == -40'sd9, "R2 ldnabs neg", 80'(storeData), 80'(-40'sd9));
  endtask

  task automatic t_mq();
    logic [W-1:0] m;
    op1(8'h01, 40'sd42, "R3 ld");
    op1(8'h09, 40'sd555, "R3 ldmq lat");
    chk(storeData == 40'sd42, "R3 ldmq keeps ac", 80'(storeData), 42);
    op1(8'h21, 40'sd1, "R3 store lat");
    chk(storeData == 40'sd42, "R3 store keeps ac", 80'(storeData), 42);
    readMq(m);
    chk(m == 40'sd555, "R3 mq2ac", 80'(m), 555);
  endtask

  task automatic t_arith();
    logic [W-1:0] mx, mn;
    mx = {1'b0, {(W-1){1'b1}}};
    mn = {1'b1, {(W-1){1'b0}}};
    op1(8'h01, 40'sd100, "R4 ld");
    op1(8'h05, -40'sd30, "R4 add lat");
    chk(storeData == 40'sd70, "R4 add", 80'(storeData), 70);
    op1(8'h07, -40'sd30, "R4 addabs lat");
    chk(storeData == 40'sd100, "R4 addabs", 80'(storeData), 100);
    op1(8'h06, 40'sd250, "R4 sub lat");
    chk(storeData == -40'sd150, "R4 sub", 80'(storeData), 80'(-40'sd150));
    op1(8'h08, -40'sd50, "R4 subabs lat");
    chk(storeData == -40'sd200, "R4 subabs", 80'(storeData), 80'(-40'sd200));
    chk(!overflow, "R4 no overflow", 80'(overflow), 0);
    op1(8'h01, mx, "R4 ld max");
    op1(8'h05, 40'sd1, "R4 add wrap lat");
    chk(storeData == mn && overflow, "R4 add wraps", {overflow, storeData}, {1'b1, mn});
    op1(8'h05, '0, "R11 add 0");
    chk(!overflow, "R11 overflow refreshed", 80'(overflow), 0);
    op1(8'h06, 40'sd1, "R4 sub wrap lat");
    chk(storeData == mx && overflow, "R4 sub wraps", {overflow, storeData}, {1'b1, mx});
  endtask

  task automatic t_shift();
    op1(8'h01, -40'sd6, "R5 ld");
    op1(8'h14, '0, "R5 shl lat");
    chk(storeData == -40'sd12 && !overflow, "R5 shl neg",
        {overflow, storeData}, {1'b0, -40'sd12});
    op1(8'h15, '0, "R5 shr lat");
    chk(storeData == -40'sd6, "R5 shr arith", 80'(storeData), 80'(-40'sd6));
    op1(8'h01, 40'sd5, "R5 ld");
    op1(8'h15, '0, "R5 shr lat");
    chk(storeData == 40'sd2, "R5 shr pos", 80'(storeData), 2);
    op1(8'h01, 40'h40_0000_0000, "R5 ld");
    op1(8'h14, '0, "R5 shl lat");
    chk(storeData == 40'h80_0000_0000 && overflow, "R5 shl overflow",
        {overflow, storeData}, {1'b1, 40'h80_0000_0000});
  endtask

  task automatic mulCase(input logic signed [W-1:0] a, input logic signed [W-1:0] b);
    logic signed [79:0] pa, pb, p;
    logic [W-1:0] m;
    int lat;
    pa = 80'(a); pb = 80'(b); p = pa * pb;
    op1(8'h09, a, "R6 ldmq");
    issue(8'h0B, b, lat);
    chk(lat == MULDIV_LAT, "R6 mul latency", 80'(lat), 80'(MULDIV_LAT));
    chk(storeData == p[79:40], "R6 product high", 80'(storeData), 80'(p[79:40]));
    readMq(m);
    chk(m == p[39:0], "R6 product low", 80'(m), 80'(p[39:0]));
  endtask

  task automatic t_mul();
    mulCase(40'sd3, 40'sd5);
    mulCase(-40'sd7, 40'sd9);
    mulCase(40'sd123456789, -40'sd987654321);
    mulCase(-40'sd274877906941, -40'sd549755813887);
    mulCase(40'sd0, -40'sd11);
  endtask

  task automatic divCase(input logic signed [W-1:0] a, input logic signed [W-1:0] b);
    logic signed [W-1:0] q, r;
    logic [W-1:0] m;
    int lat;
    q = a / b; r = a % b;
    op1(8'h01, a, "R7 ld");
    issue(8'h0C, b, lat);
    chk(lat == MULDIV_LAT, "R7 div latency", 80'(lat), 80'(MULDIV_LAT));
    chk(storeData == r && !divError, "R7 remainder", 80'(storeData), 80'(r));
    readMq(m);
    chk(m == q, "R7 quotient", 80'(m), 80'(q));
  endtask

  task automatic t_div();
    divCase(40'sd100, 40'sd7);
    divCase(-40'sd100, 40'sd7);
    divCase(40'sd100, -40'sd7);
    divCase(-40'sd100, -40'sd7);
    divCase(40'sd549755813887, 40'sd3);
    divCase(40'sd5, 40'sd9);
  endtask

  task automatic t_divzero();
    logic [W-1:0] m;
    int lat;
    op1(8'h09, 40'sd66, "R8 ldmq");
    op1(8'h01, 40'sd55, "R8 ld");
    issue(8'h0C, '0, lat);
    chk(lat == 0, "R8 zero div latency", 80'(lat), 0);
    chk(divError && storeData == 40'sd55, "R8 zero div ac kept",
        {divError, storeData}, {1'b1, 40'sd55});
    readMq(m);
    chk(m == 40'sd66, "R8 zero div mq kept", 80'(m), 66);
    chk(!divError, "R11 divError refreshed", 80'(divError), 0);
  endtask

  task automatic t_busy();
    logic [W-1:0] m;
    int lat;
    op1(8'h09, 40'sd3, "R9 ldmq");
    @(negedge clk);
    opcode = 8'h0B; operand = 40'sd5; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    opcode = 8'h01; operand = 40'sd777; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 200) begin @(negedge clk); lat++; end
    chk(storeData == '0, "R9 ignored start ac", 80'(storeData), 0);
    readMq(m);
    chk(m == 40'sd15, "R9 ignored start mq", 80'(m), 15);
  endtask

  task automatic t_unknown();
    op1(8'h01, 40'sd31, "R11 ld");
    op1(8'hFF, 40'sd999, "R11 unknown lat");
    chk(storeData == 40'sd31, "R11 unknown no change", 80'(storeData), 31);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_loads();
    t_mq();
    t_arith();
    t_shift();
    t_mul();
    t_div();
    t_divzero();
    t_busy();
    t_unknown();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1600000ns;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule